// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit chip-level control words. A host reaches it over a simple word-addressed bus that has a read strobe, a write strobe, a byte address, write data and read data. The bank only stores values. Whatever the bits later steer, such as clocks, pin multiplexing or resets, is left to logic outside the block.

A magic value held in the key word at offset 0x00 unlocks a bounded window of low-offset words. Writes inside that window are dropped while the key word holds anything else. A few offsets are read-only and one is write-only. Misaligned and out-of-range accesses are tolerated. Every illegal access raises a one-cycle error pulse so that surrounding logic can log it.

At reset each word takes a default chosen by the silicon-revision parameter. The revision word then takes the parameter value, and the two strap words take the strap input pins.

Top module: `sysctl_regbank`

## Requirements
- R1: A write whose offset lies in 0x04..0x100 inclusive is dropped unless the key word at 0x00 currently holds 0x1688A8A8. A dropped write pulses the error output.
- R2: Writes to 0x00 and to offsets 0x104..0x1A4 are never blocked by the key. Writing any value other than 0x1688A8A8 to 0x00 relocks the window, so the very next protected write is dropped.
- R3: Offsets 0x14, 0x50..0x6C, 0x78, 0x7C, 0xE0 and 0xE4 are read-only. A write to one of them leaves it unchanged and pulses the error output.
- R4: Offset 0xC0 is write-only. A read of it returns the stored word and pulses the error output.
- R5: A read above 0x1A4 returns zero and pulses the error output. A write there changes nothing and pulses the error output.
- R6: An access with a nonzero value in address bits [1:0] is invalid. Such a read returns zero, such a write is dropped, and either one pulses the error output. For aligned addresses the word index is the byte offset shifted right by two.
- R7: After reset the key word is 0, so the window is locked. Offset 0x40 reads 0x00000040, with bit 6 meaning memory initialised. Offset 0x7C reads the revision parameter, 0x70 reads strap_a and 0xD0 reads strap_b. Every other word reads 0.
- R8: Read data is registered. It appears on rd_data one cycle after the read strobe and holds between reads. The error output is high for exactly the cycle after an offending strobe.
- R9: When both strobes are given in one cycle, the read returns the contents from before the write, and the write is visible to later reads.
- R10: A revision parameter other than 0x02000303 stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a | input | 32 | Strap value loaded into offset 0x70 at reset |
| strap_b | input | 32 | Strap value loaded into offset 0xD0 at reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (17) | Byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle illegal-access flag |

## Verification
A read and a write can land in the same cycle. They may target the same word, and either one may be illegal on its own, for example a locked write combined with a read of the write-only word. Random traffic sets each strobe independently, and directed steps aim both strobes at one word. The bench predicts the read from its model as it stood before applying the write. It ORs the two error causes into a single expected pulse.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam logic [31:0] UNLOCK_KEY  = 32'h1688_A8A8;
  localparam logic [31:0] REV_BASE    = 32'h0200_0303;
  localparam int unsigned LAST_IDX    = 105;
  localparam int unsigned NUM_REGS    = LAST_IDX + 1;
  localparam int unsigned IDX_KEY     = 0;
  localparam int unsigned IDX_SCRATCH = 16;
  localparam int unsigned IDX_STRAP_A = 28;
  localparam int unsigned IDX_REV     = 31;
  localparam int unsigned IDX_WO      = 48;
  localparam int unsigned IDX_STRAP_B = 52;
  localparam int unsigned LOCK_LAST   = 64;

  function automatic logic idx_read_only(input logic [31:0] i);
    return (i == 5) || (i >= 20 && i <= 27) || (i == 30) || (i == 31) ||
           (i == 56) || (i == 57);
  endfunction

  function automatic logic idx_in_lock_window(input logic [31:0] i);
    return (i >= 1) && (i <= LOCK_LAST);
  endfunction

  function automatic logic rev_supported(input logic [31:0] rev);
    return rev == REV_BASE;
  endfunction

  function automatic logic [DATA_W-1:0] reset_word(input logic [31:0] rev,
                                                  input logic [31:0] i);
    logic [DATA_W-1:0] v;
    v = '0;
    if (rev == REV_BASE && i == IDX_SCRATCH) v = 32'h0000_0040;
    return v;
  endfunction
endpackage

// File: rtl/sysctl_access.sv
module sysctl_access
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              key_open,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_commit,
  output logic              rd_hit,
  output logic              wr_err_ev,
  output logic              rd_err_ev
);
  logic addr_ok, ro, lock_block;

  always_comb begin
    idx        = addr[ADDR_W-1:2];
    addr_ok    = (addr[1:0] == 2'b00) && (idx <= IDX_W'(LAST_IDX));
    ro         = idx_read_only(32'(idx));
    lock_block = idx_in_lock_window(32'(idx)) && !key_open;
    wr_commit  = wr_en && addr_ok && !ro && !lock_block;
    wr_err_ev  = wr_en && !wr_commit;
    rd_hit     = rd_en && addr_ok;
    rd_err_ev  = rd_en && (!addr_ok || idx == IDX_W'(IDX_WO));
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned IDX_W  = 15,
  parameter logic [31:0] REV_ID = REV_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] strap_a,
  input  logic [DATA_W-1:0] strap_b,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rword,
  output logic              key_open
);
  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] init_val;
    if (i == IDX_STRAP_A)      begin : g_sa  assign init_val = strap_a; end
    else if (i == IDX_STRAP_B) begin : g_sb  assign init_val = strap_b; end
    else if (i == IDX_REV)     begin : g_rv  assign init_val = REV_ID; end
    else                       begin : g_tb  assign init_val = reset_word(REV_ID, 32'(i)); end

    always_ff @(posedge clk) begin
      if (!rst_n)                             regs[i] <= init_val;
      else if (we && widx == IDX_W'(i))       regs[i] <= wdata;
    end

    if (idx_read_only(32'(i))) begin : g_ro_chk
      AST_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(regs[i])); // R3
    end
  end

  assign rword    = (ridx <= IDX_W'(LAST_IDX)) ? regs[ridx[SEL_W-1:0]] : '0;
  assign key_open = (regs[IDX_KEY] == UNLOCK_KEY);
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter logic [31:0] REV_ID = REV_BASE,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       strap_a,
  input  logic [31:0]       strap_b,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              err_pulse
);
  if (!rev_supported(REV_ID)) begin : g_bad_rev
    $error("sysctl_regbank: unsupported revision parameter"); // R10
  end

  logic [IDX_W-1:0]  idx;
  logic              wr_commit, rd_hit, wr_err_ev, rd_err_ev, key_open;
  logic [DATA_W-1:0] rword;

  sysctl_access #(.ADDR_W(ADDR_W)) u_access (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .key_open(key_open),
    .idx(idx), .wr_commit(wr_commit), .rd_hit(rd_hit),
    .wr_err_ev(wr_err_ev), .rd_err_ev(rd_err_ev));

  sysctl_store #(.IDX_W(IDX_W), .REV_ID(REV_ID)) u_store (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .we(wr_commit), .widx(idx), .wdata(wr_data), .ridx(idx),
    .rword(rword), .key_open(key_open));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data   <= '0;
      err_pulse <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_hit ? rword : '0;
      err_pulse <= wr_err_ev || rd_err_ev;
    end
  end

  AST_LOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] == 2'b00 && addr[ADDR_W-1:2] >= IDX_W'(1) &&
     addr[ADDR_W-1:2] <= IDX_W'(LOCK_LAST) && !key_open) |=> err_pulse); // R1
  AST_WO_READ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(IDX_WO * 4)) |=> err_pulse); // R4
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > ADDR_W'(LAST_IDX * 4)) |=> (rd_data == '0 && err_pulse)); // R5
  AST_ERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(wr_en || rd_en)); // R8
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R8
endmodule

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1688_A8A8;
  localparam logic [31:0] REV = 32'h0200_0303;
  localparam logic [31:0] SA  = 32'hA5A5_0F0F;
  localparam logic [31:0] SB  = 32'h0000_C3C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic err_pulse;

  int checks = 0, fails = 0;
  logic [31:0] mdl [0:105];
  logic [31:0] last_rd = '0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regbank i_sysctl_regbank (
    .clk(clk), .rst_n(rst_n), .strap_a(SA), .strap_b(SB),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .err_pulse(err_pulse));

  function automatic logic b_ro(int i);
    return i == 5 || (i >= 20 && i <= 27) || i == 30 || i == 31 || i == 56 || i == 57;
  endfunction

  function automatic logic [31:0] b_reset(int i);
    if (i == 16) return 32'h40;
    if (i == 28) return SA;
    if (i == 31) return REV;
    if (i == 52) return SB;
    return 32'h0;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [16:0] a,
                    input logic [31:0] d, input string tag);
    int i;
    logic ok, ee;
    i  = int'(a[16:2]);
    ok = (a[1:0] == 2'b00) && (i <= 105);
    ee = 1'b0;
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    if (r) begin
      last_rd = ok ? mdl[i] : 32'h0;
      if (!ok || i == 48) ee = 1'b1;
    end
    if (w) begin
      if (!ok || b_ro(i) || (i >= 1 && i <= 64 && mdl[0] != KEY)) ee = 1'b1;
      else mdl[i] = d;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rd_data == last_rd, tag, "rd_data", rd_data, last_rd);
    check(err_pulse == ee, tag, "err_pulse", 32'(err_pulse), 32'(ee));
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    int seed_v;
    seed_v = int'($urandom(32'd4321));
    for (int i = 0; i < 106; i++) mdl[i] = b_reset(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(rd_data == 32'h0 && err_pulse == 1'b0, "R7", "reset outputs", rd_data, 32'h0);
    // R7 reset contents
    op(0, 1, 17'h000, 0, "R7");
    op(0, 1, 17'h040, 0, "R7");
    op(0, 1, 17'h070, 0, "R7");
    op(0, 1, 17'h07C, 0, "R7");
    op(0, 1, 17'h0D0, 0, "R7");
    op(0, 1, 17'h008, 0, "R7");
    // R1 locked write dropped
    op(1, 0, 17'h008, 32'hDEAD_0001, "R1");
    op(0, 1, 17'h008, 0, "R1");
    op(1, 0, 17'h100, 32'h1234_5678, "R1");
    op(0, 1, 17'h100, 0, "R1");
    // R2 unblocked offsets while locked
    op(1, 0, 17'h104, 32'hCAFE_0104, "R2");
    op(0, 1, 17'h104, 0, "R2");
    op(1, 0, 17'h1A4, 32'h0BAD_F00D, "R2");
    op(0, 1, 17'h1A4, 0, "R2");
    // unlock, write, relock
    op(1, 0, 17'h000, KEY, "R2");
    op(1, 0, 17'h008, 32'h0000_BEEF, "R1");
    op(0, 1, 17'h008, 0, "R1");
    op(1, 0, 17'h000, 32'h1688_A8A9, "R2");
    op(1, 0, 17'h008, 32'h1111_2222, "R2");
    op(0, 1, 17'h008, 0, "R2");
    // R3 read-only with window open
    op(1, 0, 17'h000, KEY, "R3");
    op(1, 0, 17'h07C, 32'hFFFF_FFFF, "R3");
    op(0, 1, 17'h07C, 0, "R3");
    op(1, 0, 17'h014, 32'h5555_5555, "R3");
    op(1, 0, 17'h0E4, 32'h5555_5555, "R3");
    op(0, 1, 17'h0E4, 0, "R3");
    // R4 write-only
    op(1, 0, 17'h0C0, 32'h00C0_FFEE, "R4");
    op(0, 1, 17'h0C0, 0, "R4");
    // R5 out of range
    op(0, 1, 17'h1A8, 0, "R5");
    op(1, 0, 17'h1FFFC, 32'h1, "R5");
    // R6 misaligned
    op(0, 1, 17'h009, 0, "R6");
    op(1, 0, 17'h10A, 32'h7777_7777, "R6");
    op(0, 1, 17'h108, 0, "R6");
    // R8 idle cycles: error clears, data holds
    op(0, 0, 17'h000, 0, "R8");
    // R9 same-cycle read and write
    op(1, 1, 17'h104, 32'h9999_0000, "R9");
    op(0, 1, 17'h104, 0, "R9");
    op(1, 1, 17'h0C0, 32'h4444_0000, "R9");
    // random traffic, R8 and R9 interplay
    for (int n = 0; n < 4000; n++) begin
      logic w, r;
      logic [16:0] a;
      logic [31:0] d;
      w = ($urandom_range(0, 2) != 0);
      r = ($urandom_range(0, 1) != 0);
      d = $urandom();
      if ($urandom_range(0, 7) == 0) begin
        a = 17'h0;
        if ($urandom_range(0, 1) == 0) d = KEY;
      end else begin
        a = 17'($urandom_range(0, 110) * 4);
        if ($urandom_range(0, 15) == 0) a[1:0] = 2'($urandom_range(1, 3));
      end
      op(w, r, a, d, "R9");
    end
    done = 1'b1;
    report();
  end
endmodule